// File: doc/BRIEF.md
# Decimal Ten's-Complement Word ALU

This block is a purely combinational arithmetic unit for signed decimal words. A word holds a four-digit decimal number (0 to 9999) carried as an unsigned binary value. Negative numbers use ten's complement, so 9999 stands for -1 and 5000 to 9999 form the negative half. Every arithmetic result wraps modulo 10000, which is the decimal counterpart of binary two's-complement wrap.

A datapath puts two operand words and a 4-bit operation code on the inputs and reads the result word in the same cycle. The unit covers add, subtract, increment, decrement, negate, clear, multiply by ten and divide by ten. It also has a pass-through, which a register-to-register move can use. A separate flag goes high when either operand lies outside the legal decimal range. The digit count is a parameter, and the modulus and port widths are derived from it.

Top module: `dec_word_alu`

## Requirements
- R1: Code 1 (add) gives (op_a + op_b) mod 10000. For example, 9999 + 9999 gives 9998.
- R2: Code 2 (subtract) gives (op_a + 10000 - op_b) mod 10000. For example, 5 - 7 gives 9998 and 0 - 0 gives 0.
- R3: Code 3 (increment) gives (op_a + 1) mod 10000, so 9999 becomes 0. op_b has no effect on the result.
- R4: Code 4 (decrement) gives (op_a + 9999) mod 10000, so 0 becomes 9999.
- R5: Code 5 (negate) gives (10000 - op_a) mod 10000, so 0 maps to 0, 1 maps to 9999 and 9999 maps to 1.
- R6: Code 6 (clear) gives 0 for any operands.
- R7: Code 7 (multiply by ten) gives (op_a * 10) mod 10000, which drops the leading digit. For example, 1234 gives 2340.
- R8: Code 8 (divide by ten) gives the integer quotient op_a / 10, with a zero moved into the leading digit. For example, 1234 gives 123.
- R9: Code 0, and every unused code from 9 to 15, passes op_a to the result unchanged.
- R10: bad_operand is 1 exactly when op_a or op_b exceeds 9999, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| op_a | input | 14 | First operand; also the only operand of unary operations |
| op_b | input | 14 | Second operand, used by add and subtract |
| result | output | 14 | Result word, reduced modulo 10000 |
| bad_operand | output | 1 | High when an operand is above 9999 |

## Verification
Every result and the range flag are due in the same cycle as the stimulus, because no register lies between the inputs and the outputs. The bench applies each stimulus just after a rising clock edge and samples result and bad_operand at the following falling edge. By then the combinational path has settled, and no input has moved since it was applied. The wrap points get their own vectors: the sum reaching exactly 10000, increment of 9999, decrement of 0, negation of 0 and 9999, and digit loss at both shift ends.

// File: rtl/dec_word_alu.sv
module dec_word_alu #(
  parameter  int DIGITS = 4,
  localparam int MOD    = 10 ** DIGITS,
  localparam int W      = $clog2(MOD)
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] result,
  output logic         bad_operand
);

  localparam logic [3:0] OP_PASS = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_INC  = 4'd3;
  localparam logic [3:0] OP_DEC  = 4'd4;
  localparam logic [3:0] OP_NEG  = 4'd5;
  localparam logic [3:0] OP_CLR  = 4'd6;
  localparam logic [3:0] OP_MUL  = 4'd7;
  localparam logic [3:0] OP_DIV  = 4'd8;

  localparam logic [W:0]   MODX = (W+1)'(MOD);
  localparam logic [W:0]   ONEX = (W+1)'(1);
  localparam logic [W+3:0] MODL = (W+4)'(MOD);
  localparam logic [W-1:0] TEN  = W'(10);

  function automatic logic [W-1:0] fold(input logic [W:0] x);
    logic [W:0] t;
    t = (x >= MODX) ? x - MODX : x;
    return t[W-1:0];
  endfunction

  logic [W:0]   ax, bx;
  logic [W+3:0] prod, prod_rem;

  assign ax       = {1'b0, op_a};
  assign bx       = {1'b0, op_b};
  assign prod     = {1'b0, op_a, 3'b000} + {3'b000, op_a, 1'b0};
  assign prod_rem = prod % MODL;

  assign bad_operand = (ax >= MODX) || (bx >= MODX);

  always_comb begin
    case (op_sel)
      OP_ADD:  result = fold(ax + bx);
      OP_SUB:  result = fold(ax + (MODX - bx));
      OP_INC:  result = fold(ax + ONEX);
      OP_DEC:  result = fold(ax + (MODX - ONEX));
      OP_NEG:  result = fold(MODX - ax);
      OP_CLR:  result = '0;
      OP_MUL:  result = prod_rem[W-1:0];
      OP_DIV:  result = op_a / TEN;
      default: result = op_a;
    endcase
  end

  logic [W:0]   chk_neg;
  logic [W+3:0] chk_r10, chk_a;

  always_comb begin
    chk_neg = {1'b0, result} + ax;
    chk_r10 = {1'b0, result, 3'b000} + {3'b000, result, 1'b0};
    chk_a   = {4'b0000, op_a};
    if (!bad_operand) begin
      a_r1_in_range: assert (result < MOD[W-1:0])
        else $error("result outside decimal range");
      if (op_sel == OP_NEG)
        a_r5_neg_sums_zero: assert (chk_neg == '0 || chk_neg == MODX)
          else $error("negate does not cancel operand");
      if (op_sel == OP_INC)
        a_r3_inc_wrap: assert ((result == '0) == (op_a == MOD[W-1:0] - 1'b1))
          else $error("increment wrap mismatch");
      if (op_sel == OP_DIV)
        a_r8_div_bounds: assert (chk_r10 <= chk_a && chk_a < chk_r10 + (W+4)'(10))
          else $error("divide by ten outside bounds");
      if (op_sel == OP_CLR)
        a_r6_clear_zero: assert (result == '0)
          else $error("clear not zero");
    end
  end

endmodule

// File: tb/dec_word_alu_tb.sv
module dec_word_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic [3:0]  op;
    logic [13:0] a;
    logic [13:0] b;
    logic [13:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd1, 14'd1234, 14'd8766, 14'd0},
    '{4'd1, 14'd9999, 14'd9999, 14'd9998},
    '{4'd1, 14'd12,   14'd34,   14'd46},
    '{4'd2, 14'd5,    14'd7,    14'd9998},
    '{4'd2, 14'd100,  14'd100,  14'd0},
    '{4'd2, 14'd0,    14'd0,    14'd0},
    '{4'd2, 14'd9999, 14'd0,    14'd9999},
    '{4'd3, 14'd9999, 14'd0,    14'd0},
    '{4'd3, 14'd41,   14'd0,    14'd42},
    '{4'd4, 14'd0,    14'd0,    14'd9999},
    '{4'd4, 14'd1234, 14'd0,    14'd1233},
    '{4'd5, 14'd0,    14'd0,    14'd0},
    '{4'd5, 14'd9999, 14'd0,    14'd1},
    '{4'd5, 14'd1,    14'd0,    14'd9999},
    '{4'd6, 14'd4321, 14'd77,   14'd0},
    '{4'd7, 14'd1234, 14'd0,    14'd2340},
    '{4'd7, 14'd9999, 14'd0,    14'd9990},
    '{4'd8, 14'd1234, 14'd0,    14'd123},
    '{4'd8, 14'd9,    14'd0,    14'd0},
    '{4'd0, 14'd777,  14'd5,    14'd777},
    '{4'd15, 14'd4242, 14'd1,   14'd4242},
    '{4'd9, 14'd1,    14'd0,    14'd1},
    '{4'd12, 14'd9999, 14'd3,   14'd9999},
    '{4'd8, 14'd9999, 14'd0,    14'd999}
  };

  logic        clk = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [13:0] op_a = '0;
  logic [13:0] op_b = '0;
  logic [13:0] result;
  logic        bad_operand;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_word_alu u_dut (
    .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
    .result(result), .bad_operand(bad_operand)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [13:0] a, input logic [13:0] b);
    @(posedge clk);
    op_sel = op; op_a = a; op_b = b;
    @(negedge clk);
  endtask

  task automatic check_res(input string req, input logic [13:0] exp);
    total++;
    if (result !== exp) begin
      bad++;
      $display("FAIL %s result=%0d expected=%0d", req, result, exp);
    end
  endtask

  task automatic check_flag(input string req, input logic exp);
    total++;
    if (bad_operand !== exp) begin
      bad++;
      $display("FAIL %s bad_operand=%0d expected=%0d", req, bad_operand, exp);
    end
  endtask

  initial begin
    // idle state: all-zero inputs give pass-through of zero (R9), flag low (R10)
    @(negedge clk);
    check_res("R9", 14'd0);
    check_flag("R10", 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].a, VEC[i].b);
      check_res(req_of(VEC[i].op), VEC[i].exp);
    end

    // R3: op_b ignored by increment
    apply(4'd3, 14'd500, 14'd9000);
    check_res("R3", 14'd501);
    // R6: clear ignores both operands
    apply(4'd6, 14'd9999, 14'd9999);
    check_res("R6", 14'd0);
    // R10: range flag
    apply(4'd0, 14'd9999, 14'd9999);
    check_flag("R10", 1'b0);
    apply(4'd0, 14'd10000, 14'd0);
    check_flag("R10", 1'b1);
    apply(4'd1, 14'd0, 14'd16383);
    check_flag("R10", 1'b1);
    apply(4'd1, 14'd0, 14'd0);
    check_flag("R10", 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule